// File: doc/BRIEF.md
# Clock Source Switch Control Register

A 16-bit control and status register that governs which clock source a small processor system runs from. Software writes a new-source code, two oscillator enable bits, a selection lock bit, an I/O lock bit and a switch request bit. It reads back the current source, a PLL lock status bit and a fault flag. The block runs a short switch handshake with a clock multiplexer. The multiplexer here is represented only by a ready input. A pending request is completed when the multiplexer is ready. The new code is then copied into the current-source field and the request bit clears.

Three protections are built in. While the fail-safe monitor is enabled, setting the selection lock freezes the new-source field and the request bit. The I/O lock bit changes only in the cycle right after a two-write key sequence. A one-way configuration input makes that bit sticky once it is set. The fault flag is set by hardware, including when a request names the reserved source code. Software can only clear it. The PLL lock status bit follows the PLL only while a PLL source is current, and it drops on every completed switch.

Top module: `clksw_ctrl`

## Requirements
- R1: While `rst_ni` is low, both source fields load `cfg_src_i` and every other bit reads 0. Bits 15, 11 and 4 always read 0.
- R2: Read layout: current source in bits 14:12, new source in 10:8, selection lock bit 7, I/O lock bit 6, PLL status bit 5, fault bit 3, primary enable bit 2, secondary enable bit 1, request bit 0. A register write updates the new source, both enables and the selection lock. Writes to bits 15, 11, 5, 4 and 14:12 have no effect.
- R3: Writing 1 to bit 0 sets the request, and writing 0 does nothing. At the first clock edge where the request is 1 and `mux_ready_i` is 1, the current source takes the new source and the request clears on that same edge. While ready is 0 the request and the current source hold.
- R4: Source code 110 is reserved. A request completing with new source 110 clears the request, leaves the current source unchanged and sets the fault flag.
- R5: With `fscm_cfg_i` = 00 and the selection lock bit at 1, register writes leave the new-source field and the request bit unchanged.
- R6: With `fscm_cfg_i[1]` = 1 the selection lock bit has no effect, and the new source and the request remain writable.
- R7: The unlock sequence is a write of `KEY_A` to `KEY_ADDR`, followed by a write of `KEY_B` to `KEY_ADDR`, with no other write in between. The I/O lock bit takes bit 6 of a register write only when that write is on the clock edge right after the `KEY_B` write. Otherwise bit 6 writes are ignored.
- R8: With `oneway_i` = 1, a set I/O lock bit cannot be cleared, even after an unlock sequence.
- R9: Writing 0 to bit 3 clears the fault flag, and writing 1 has no effect. `fault_i` high at a clock edge sets the flag, and setting wins over a clear on the same edge.
- R10: The PLL status bit is 0 after the edge that completes a switch. On later edges it takes `pll_locked_i` when the current source is 001 or 011, and 0 for any other source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_src_i | input | 3 | Source code loaded at reset |
| fscm_cfg_i | input | 2 | Fail-safe monitor configuration (00 = enabled) |
| oneway_i | input | 1 | Makes the I/O lock bit set-only |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | ADDR_W | Write address (register or key) |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Register read-back |
| mux_ready_i | input | 1 | Clock multiplexer ready to switch |
| pll_locked_i | input | 1 | PLL locked or start-up timer expired |
| fault_i | input | 1 | Hardware clock fault event |

## Verification
Register writes appear on `rd_data_o` one edge after the write strobe. A switch completes one edge after the request is set, if ready is already high. Otherwise it completes on the first edge where ready is high. The PLL status bit is 0 right after that edge and follows `pll_locked_i` one edge later. The bench drives inputs and reads the whole register on falling edges. Each scenario task counts those edges explicitly and checks after every step, so every late, early or missing update is visible. The unlock window is tested with back-to-back writes, with an intervening write, and with one idle cycle before the register write.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int DW = 16;
  localparam int SW = 3;

  localparam logic [SW-1:0] SRC_FRC_PLL = 3'b001;
  localparam logic [SW-1:0] SRC_PRI_PLL = 3'b011;
  localparam logic [SW-1:0] SRC_RSVD    = 3'b110;

  localparam int B_REQ    = 0;
  localparam int B_SEC_EN = 1;
  localparam int B_PRI_EN = 2;
  localparam int B_FAULT  = 3;
  localparam int B_PLL_LK = 5;
  localparam int B_IO_LK  = 6;
  localparam int B_SEL_LK = 7;
  localparam int NSRC_LO  = 8;
  localparam int CSRC_LO  = 12;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlock_e;

  function automatic logic is_pll(logic [SW-1:0] s);
    return (s == SRC_FRC_PLL) || (s == SRC_PRI_PLL);
  endfunction
endpackage

// File: rtl/clksw_unlock.sv
module clksw_unlock
  import clksw_pkg::*;
#(
  parameter logic [DW-1:0] KEY_A = 16'h5A3C,
  parameter logic [DW-1:0] KEY_B = 16'hC3A5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          key_hit_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          open_o
);
  unlock_e st_q, st_d;
  logic    key_a_wr, key_b_wr;

  assign key_a_wr = wr_en_i && key_hit_i && (wr_data_i == KEY_A);
  assign key_b_wr = wr_en_i && key_hit_i && (wr_data_i == KEY_B);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      UL_IDLE: if (key_a_wr) st_d = UL_HALF;
      UL_HALF: if (wr_en_i) st_d = key_b_wr ? UL_OPEN : (key_a_wr ? UL_HALF : UL_IDLE);
      UL_OPEN: st_d = key_a_wr ? UL_HALF : UL_IDLE;
      default: st_d = UL_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= UL_IDLE;
    else         st_q <= st_d;

  assign open_o = (st_q == UL_OPEN);

  a_r7_window_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |=> !open_o);
  a_r7_window_after_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(wr_en_i && key_hit_i && wr_data_i == KEY_B));
endmodule

// File: rtl/clksw_switch.sv
module clksw_switch
  import clksw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] cfg_src_i,
  input  logic          req_i,
  input  logic          ready_i,
  input  logic [SW-1:0] nsrc_i,
  input  logic          pll_locked_i,
  output logic [SW-1:0] csrc_o,
  output logic          done_o,
  output logic          reject_o,
  output logic          pll_lk_o
);
  logic [SW-1:0] csrc_q;
  logic          lk_q, fire;

  assign fire     = req_i && ready_i;
  assign done_o   = fire && (nsrc_i != SRC_RSVD);
  assign reject_o = fire && (nsrc_i == SRC_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     csrc_q <= cfg_src_i;
    else if (done_o) csrc_q <= nsrc_i;

  // status drops on a switch, then follows the PLL only for PLL sources
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     lk_q <= 1'b0;
    else if (done_o) lk_q <= 1'b0;
    else             lk_q <= pll_locked_i && is_pll(csrc_q);

  assign csrc_o   = csrc_q;
  assign pll_lk_o = lk_q;

  a_r3_csrc_only_on_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(csrc_q) |-> $past(req_i && ready_i));
  a_r4_reject_keeps_csrc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |=> $stable(csrc_q));
  a_r10_lock_drops_on_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !lk_q);
  a_r10_lock_needs_pll_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_q |-> $past(is_pll(csrc_q) && pll_locked_i));
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter int              REG_ADDR = 0,
  parameter int              KEY_ADDR = 1,
  parameter logic [DW-1:0]   KEY_A    = 16'h5A3C,
  parameter logic [DW-1:0]   KEY_B    = 16'hC3A5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SW-1:0]     cfg_src_i,
  input  logic [1:0]        fscm_cfg_i,
  input  logic              oneway_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              mux_ready_i,
  input  logic              pll_locked_i,
  input  logic              fault_i
);
  logic [SW-1:0] nsrc_q, csrc;
  logic sel_lk_q, io_lk_q, fault_q, pri_en_q, sec_en_q, req_q;
  logic wr_reg, key_hit, sel_locked, unlock_open, done, reject, pll_lk;

  assign wr_reg     = wr_en_i && (wr_addr_i == ADDR_W'(REG_ADDR));
  assign key_hit    = (wr_addr_i == ADDR_W'(KEY_ADDR));
  assign sel_locked = (fscm_cfg_i == 2'b00) && sel_lk_q;

  clksw_unlock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) i_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .key_hit_i (key_hit),
    .wr_data_i (wr_data_i),
    .open_o    (unlock_open)
  );

  clksw_switch i_switch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_src_i    (cfg_src_i),
    .req_i        (req_q),
    .ready_i      (mux_ready_i),
    .nsrc_i       (nsrc_q),
    .pll_locked_i (pll_locked_i),
    .csrc_o       (csrc),
    .done_o       (done),
    .reject_o     (reject),
    .pll_lk_o     (pll_lk)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      nsrc_q   <= cfg_src_i;
      sel_lk_q <= 1'b0;
      pri_en_q <= 1'b0;
      sec_en_q <= 1'b0;
    end else if (wr_reg) begin
      sel_lk_q <= wr_data_i[B_SEL_LK];
      pri_en_q <= wr_data_i[B_PRI_EN];
      sec_en_q <= wr_data_i[B_SEC_EN];
      if (!sel_locked) nsrc_q <= wr_data_i[NSRC_LO +: SW];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                          io_lk_q <= 1'b0;
    else if (wr_reg && unlock_open && !(oneway_i && io_lk_q)) io_lk_q <= wr_data_i[B_IO_LK];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                        req_q <= 1'b0;
    else if (done || reject)                            req_q <= 1'b0;
    else if (wr_reg && !sel_locked && wr_data_i[B_REQ]) req_q <= 1'b1;

  // set has priority over a software clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                              fault_q <= 1'b0;
    else if (fault_i || reject)               fault_q <= 1'b1;
    else if (wr_reg && !wr_data_i[B_FAULT])   fault_q <= 1'b0;

  always_comb begin
    rd_data_o                 = '0;
    rd_data_o[CSRC_LO +: SW]  = csrc;
    rd_data_o[NSRC_LO +: SW]  = nsrc_q;
    rd_data_o[B_SEL_LK]       = sel_lk_q;
    rd_data_o[B_IO_LK]        = io_lk_q;
    rd_data_o[B_PLL_LK]       = pll_lk;
    rd_data_o[B_FAULT]        = fault_q;
    rd_data_o[B_PRI_EN]       = pri_en_q;
    rd_data_o[B_SEC_EN]       = sec_en_q;
    rd_data_o[B_REQ]          = req_q;
  end

  a_r5_locked_nsrc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_reg && sel_locked) |=> $stable(nsrc_q));
  a_r5_locked_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_locked && !req_q) |=> !req_q);
  a_r7_io_lock_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(io_lk_q) |-> $past(wr_reg && unlock_open));
  a_r8_oneway_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oneway_i && io_lk_q) |=> io_lk_q);
  a_r9_fault_set_by_hw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(fault_i || reject));
endmodule

// File: tb/test_clksw_ctrl.sv
`timescale 1ns/1ps
module test_clksw_ctrl;
  localparam logic [3:0]  REG = 4'd0;
  localparam logic [3:0]  KEY = 4'd1;
  localparam logic [15:0] KA  = 16'h5A3C;
  localparam logic [15:0] KB  = 16'hC3A5;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0]  cfg_src_i = 3'b010;
  logic [1:0]  fscm_cfg_i = 2'b00;
  logic        oneway_i = 1'b0, wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        mux_ready_i = 1'b0, pll_locked_i = 1'b1, fault_i = 1'b0;
  int checks = 0, failures = 0;

  always #2.5 clk_i = ~clk_i;

  clksw_ctrl i_clksw_ctrl (
    .clk_i, .rst_ni, .cfg_src_i, .fscm_cfg_i, .oneway_i, .wr_en_i, .wr_addr_i,
    .wr_data_i, .rd_data_o, .mux_ready_i, .pll_locked_i, .fault_i
  );

  task automatic chk(input string tag, input logic [15:0] exp);
    checks++;
    if (rd_data_o !== exp) begin
      failures++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data_o, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset value", 16'h2200);
  endtask

  task automatic t_rw();
    wr(REG, 16'h8916);
    chk("R2 write layout, reserved bits stay 0", 16'h2106);
  endtask

  task automatic t_switch();
    wr(REG, 16'h0101);
    chk("R3 request pending", 16'h2101);
    tick(); tick();
    chk("R3 holds without ready", 16'h2101);
    mux_ready_i = 1'b1;
    tick();
    chk("R3 switch done, R10 status low after switch", 16'h1100);
    tick();
    chk("R10 status follows PLL", 16'h1120);
    pll_locked_i = 1'b0; tick();
    chk("R10 PLL unlocked", 16'h1100);
    pll_locked_i = 1'b1; tick();
    chk("R10 PLL relocked", 16'h1120);
    wr(REG, 16'h0001); tick();
    chk("R3 switch to 000, R10 status low", 16'h0000);
    tick();
    chk("R10 non-PLL source keeps status low", 16'h0000);
  endtask

  task automatic t_reserved();
    wr(REG, 16'h0601); tick();
    chk("R4 reserved code rejected", 16'h0608);
    wr(REG, 16'h0600);
    chk("R9 software clear", 16'h0600);
    wr(REG, 16'h0608);
    chk("R9 writing 1 has no effect", 16'h0600);
    fault_i = 1'b1; wr(REG, 16'h0600); fault_i = 1'b0;
    chk("R9 hardware set wins over clear", 16'h0608);
    wr(REG, 16'h0000);
    chk("R9 clear again", 16'h0000);
  endtask

  task automatic t_sel_lock();
    fscm_cfg_i = 2'b00;
    wr(REG, 16'h0080);
    chk("R5 lock bit set", 16'h0080);
    wr(REG, 16'h0381);
    chk("R5 nsrc and request ignored", 16'h0080);
    tick();
    chk("R5 no switch while locked", 16'h0080);
    fscm_cfg_i = 2'b10;
    wr(REG, 16'h0381); tick();
    chk("R6 monitor off: switch allowed", 16'h3380);
    tick();
    chk("R6 PLL status after switch", 16'h33A0);
    wr(REG, 16'h0000);
    chk("R6 lock bit cleared", 16'h3020);
    fscm_cfg_i = 2'b00;
    wr(REG, 16'h0001); tick();
    chk("R3 back to 000", 16'h0000);
  endtask

  task automatic t_io_lock();
    oneway_i = 1'b0;
    wr(REG, 16'h0040);
    chk("R7 no unlock: bit 6 ignored", 16'h0000);
    wr(KEY, KA); wr(KEY, KB); wr(REG, 16'h0040);
    chk("R7 unlocked set", 16'h0040);
    wr(KEY, KA); wr(KEY, KB); wr(REG, 16'h0000);
    chk("R7 unlocked clear", 16'h0000);
    wr(KEY, KA); wr(REG, 16'h0000); wr(KEY, KB); wr(REG, 16'h0040);
    chk("R7 intervening write cancels", 16'h0000);
    wr(KEY, KA); wr(KEY, KB); tick(); wr(REG, 16'h0040);
    chk("R7 window is one cycle", 16'h0000);
    oneway_i = 1'b1;
    wr(KEY, KA); wr(KEY, KB); wr(REG, 16'h0040);
    chk("R8 set under one-way", 16'h0040);
    wr(KEY, KA); wr(KEY, KB); wr(REG, 16'h0000);
    chk("R8 clear refused", 16'h0040);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_rw();
    t_switch();
    t_reserved();
    t_sel_lock();
    t_io_lock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    checks++; failures++;
    $display("FAIL watchdog: run=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule